// File: doc/BRIEF.md
# Multichannel Window Threshold Alert Monitor

This block watches a stream of 10-bit conversion results, each tagged with one of eight channel numbers. Every channel has its own lower and upper limit. A result outside that window sets the channel's sticky alert bit. A per-channel routing mask selects which of four active-low fault outputs the sticky bit drives. Every alert, whatever the mask, also raises a latched active-low bus-alert request toward the host.

The host programs limits, masks, status clears and the monitoring-mode bit through a write-only register port. The host sees the sticky alert vector directly on an output. To drop the bus-alert request, the host first leaves monitoring mode and then pulses the alert-response acknowledge input. While monitoring is off, incoming results are not compared.

Top module: `window_alert_monitor`

## Requirements
- R1: Each of the eight channels has a 10-bit low limit at register address 0..7 and a 10-bit high limit at address 8..15 (address = base + channel). A write replaces that limit with regWrData[9:0].
- R2: A valid result on channel c is out of window when it is strictly greater than c's high limit or strictly less than c's low limit. A result equal to either limit is in range.
- R3: A result presented before clock edge N shows up in alertStatus and in the fault outputs just after edge N+1, and not after edge N.
- R4: alertStatus bit c is sticky. Writing address 24 clears each bit where regWrData[7:0] has a one. A new alert on the same bit in the same cycle wins over the clear.
- R5: Address 16+c holds channel c's 4-bit routing mask: bit0 healthy, bit1 fault, bit2 fault interrupt, bit3 limit interrupt. The mask resets to 4'hF. Output k is active when any channel has both its sticky bit and mask bit k set. healthyN is low when no routed alert is present and high otherwise. faultN, faultIrqN and limIrqN go low when active.
- R6: busAlertN goes low with any new alert, whatever the masks. It stays low until it is cleared as R7 describes, even if alertStatus is cleared.
- R7: Monitoring mode is bit 0 of address 25 and resets to 1. An arAck pulse clears the bus alert only while monitoring mode is 0. arAck is ignored while monitoring mode is 1. A new alert in the same cycle wins over arAck.
- R8: While monitoring mode is 0, results are not compared and set no alert.
- R9: After reset, all low limits are 0, all high limits are 1023, alertStatus is 0, healthyN is low, and faultN, faultIrqN, limIrqN and busAlertN are high. No result can then cause an alert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Conversion result strobe |
| sampleChan | input | 3 | Channel tag of the result |
| sampleData | input | 10 | Conversion result |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register address |
| regWrData | input | 10 | Register write data |
| arAck | input | 1 | Alert-response acknowledge pulse |
| healthyN | output | 1 | Low while no routed alert is present |
| faultN | output | 1 | Active-low fault flag |
| faultIrqN | output | 1 | Active-low fault interrupt |
| limIrqN | output | 1 | Active-low limit interrupt |
| busAlertN | output | 1 | Active-low latched bus-alert request |
| alertStatus | output | 8 | Sticky per-channel alert bits |

## Verification
A wrong limit or an off-by-one compare shows up as a wrongly set or missing bit on alertStatus exactly two edges after the offending result. A corrupted routing mask shows on the four fault outputs in the same cycle the sticky bit appears. A latch fault in the bus-alert logic shows on busAlertN: it is either released early, without a permitted acknowledge, or it stays low after one. Because every output is compared against the model after every cycle, any of these faults is reported within one cycle of becoming visible.

// File: rtl/wam_pkg.sv
package wam_pkg;
  localparam int NUM_CH   = 8;
  localparam int DATA_W   = 10;
  localparam int CH_IDX_W = $clog2(NUM_CH);
  localparam int ADDR_W   = CH_IDX_W + 2;
  localparam int NUM_OUT  = 4;
  localparam int REG_W    = DATA_W;

  localparam logic [DATA_W-1:0] LIMIT_MAX = '1;

  // register groups selected by the two top address bits
  localparam logic [1:0] GRP_LOW  = 2'd0;
  localparam logic [1:0] GRP_HIGH = 2'd1;
  localparam logic [1:0] GRP_MASK = 2'd2;
  localparam logic [1:0] GRP_MISC = 2'd3;
  localparam logic [CH_IDX_W-1:0] MISC_CLR = 0;
  localparam logic [CH_IDX_W-1:0] MISC_MON = 1;

  typedef struct packed {
    logic [NUM_CH-1:0] wrLow;
    logic [NUM_CH-1:0] wrHigh;
    logic [NUM_CH-1:0] wrMask;
    logic [NUM_CH-1:0] clrSticky;
    logic [REG_W-1:0]  wrData;
    logic              sampleEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/wam_ctrl.sv
module wam_ctrl
  import wam_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              arAck,
  input  logic              anyHit,
  output ctrlStrobes_t      strb,
  output logic              busAlertN
);
  logic monEn;
  logic monWr;
  logic busAlert;
  logic [1:0] grp;
  logic [CH_IDX_W-1:0] idx;

  assign grp = regAddr[ADDR_W-1:ADDR_W-2];
  assign idx = regAddr[CH_IDX_W-1:0];

  always_comb begin
    strb = '0;
    strb.wrData   = regWrData;
    strb.sampleEn = monEn;
    monWr = 1'b0;
    if (regWrEn) begin
      unique case (grp)
        GRP_LOW:  strb.wrLow[idx]  = 1'b1;
        GRP_HIGH: strb.wrHigh[idx] = 1'b1;
        GRP_MASK: strb.wrMask[idx] = 1'b1;
        default: begin
          if (idx == MISC_CLR) strb.clrSticky = regWrData[NUM_CH-1:0];
          else if (idx == MISC_MON) monWr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      monEn    <= 1'b1;
      busAlert <= 1'b0;
    end else begin
      if (monWr) monEn <= regWrData[0];
      if (anyHit) busAlert <= 1'b1;
      else if (arAck && !monEn) busAlert <= 1'b0;
    end
  end

  assign busAlertN = ~busAlert;
endmodule

// File: rtl/wam_datapath.sv
module wam_datapath
  import wam_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlStrobes_t        strb,
  input  logic                sampleValid,
  input  logic [CH_IDX_W-1:0] sampleChan,
  input  logic [DATA_W-1:0]   sampleData,
  output logic [NUM_CH-1:0]   sticky,
  output logic [NUM_OUT-1:0]  outActive,
  output logic                anyHit
);
  logic [NUM_CH-1:0]  hitNow;
  logic [NUM_CH-1:0]  hitQ;
  logic [NUM_OUT-1:0] maskCol [NUM_CH];

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CH; gc++) begin : g_ch
      logic [DATA_W-1:0]  lowLim;
      logic [DATA_W-1:0]  highLim;
      logic [NUM_OUT-1:0] routeMask;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lowLim    <= '0;
          highLim   <= LIMIT_MAX;
          routeMask <= '1;
        end else begin
          if (strb.wrLow[gc])  lowLim    <= strb.wrData[DATA_W-1:0];
          if (strb.wrHigh[gc]) highLim   <= strb.wrData[DATA_W-1:0];
          if (strb.wrMask[gc]) routeMask <= strb.wrData[NUM_OUT-1:0];
        end
      end

      assign hitNow[gc] = sampleValid && strb.sampleEn &&
                          (sampleChan == CH_IDX_W'(gc)) &&
                          ((sampleData > highLim) || (sampleData < lowLim));
      assign maskCol[gc] = routeMask;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hitQ   <= '0;
      sticky <= '0;
    end else begin
      hitQ   <= hitNow;
      sticky <= (sticky & ~strb.clrSticky) | hitQ;
    end
  end

  assign anyHit = |hitQ;

  genvar go;
  generate
    for (go = 0; go < NUM_OUT; go++) begin : g_out
      logic [NUM_CH-1:0] routed;
      always_comb begin
        for (int c = 0; c < NUM_CH; c++) routed[c] = sticky[c] & maskCol[c][go];
      end
      assign outActive[go] = |routed;
    end
  endgenerate
endmodule

// File: rtl/window_alert_monitor.sv
module window_alert_monitor
  import wam_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sampleValid,
  input  logic [CH_IDX_W-1:0] sampleChan,
  input  logic [DATA_W-1:0]   sampleData,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWrData,
  input  logic                arAck,
  output logic                healthyN,
  output logic                faultN,
  output logic                faultIrqN,
  output logic                limIrqN,
  output logic                busAlertN,
  output logic [NUM_CH-1:0]   alertStatus
);
  ctrlStrobes_t       strb;
  logic               anyHit;
  logic [NUM_OUT-1:0] outActive;

  wam_ctrl u_ctrl (
    .clk, .rst_n, .regWrEn, .regAddr, .regWrData, .arAck,
    .anyHit, .strb, .busAlertN
  );

  wam_datapath u_dp (
    .clk, .rst_n, .strb, .sampleValid, .sampleChan, .sampleData,
    .sticky(alertStatus), .outActive, .anyHit
  );

  assign healthyN  =  outActive[0];
  assign faultN    = ~outActive[1];
  assign faultIrqN = ~outActive[2];
  assign limIrqN   = ~outActive[3];
endmodule

// File: rtl/wam_checker.sv
module wam_checker
  import wam_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sampleValid,
  input logic              regWrEn,
  input logic              arAck,
  input logic              healthyN,
  input logic              busAlertN,
  input logic [NUM_CH-1:0] alertStatus
);
  assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !regWrEn |=> ((alertStatus & $past(alertStatus)) == $past(alertStatus)));

  assert_one_new_alert_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alertStatus & ~$past(alertStatus)));

  assert_set_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((alertStatus & ~$past(alertStatus)) != '0) |-> $past(sampleValid, 2));

  assert_bus_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busAlertN && !arAck) |=> !busAlertN);

  assert_bus_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busAlertN) |-> (alertStatus != '0));

  assert_healthy_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    healthyN |-> (alertStatus != '0));
endmodule

bind window_alert_monitor wam_checker u_chk (.*);

// File: tb/window_alert_monitor_tb.sv
`timescale 1ns/1ps
module window_alert_monitor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sampleValid = 1'b0;
  logic [2:0] sampleChan = '0;
  logic [9:0] sampleData = '0;
  logic regWrEn = 1'b0;
  logic [4:0] regAddr = '0;
  logic [9:0] regWrData = '0;
  logic arAck = 1'b0;
  logic healthyN, faultN, faultIrqN, limIrqN, busAlertN;
  logic [7:0] alertStatus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model
  logic [9:0] mLo [8];
  logic [9:0] mHi [8];
  logic [3:0] mMask [8];
  logic [7:0] mSticky, mPend;
  logic mBus, mMon;

  window_alert_monitor u_dut (.*);

  always #2.5 clk = ~clk;

  function automatic logic routed(input int k);
    logic r = 1'b0;
    for (int c = 0; c < 8; c++) r |= mSticky[c] & mMask[c][k];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " alertStatus"}, 32'(alertStatus), 32'(mSticky));
    chk({tag, " healthyN"},    32'(healthyN),  32'(routed(0)));
    chk({tag, " faultN"},      32'(faultN),    32'(!routed(1)));
    chk({tag, " faultIrqN"},   32'(faultIrqN), 32'(!routed(2)));
    chk({tag, " limIrqN"},     32'(limIrqN),   32'(!routed(3)));
    chk({tag, " busAlertN"},   32'(busAlertN), 32'(!mBus));
  endtask

  task automatic cyc(input logic v, input logic [2:0] ch, input logic [9:0] d,
                     input logic wr, input logic [4:0] a, input logic [9:0] wd,
                     input logic ack, input string tag);
    logic [7:0] hit, clr;
    sampleValid = v; sampleChan = ch; sampleData = d;
    regWrEn = wr; regAddr = a; regWrData = wd; arAck = ack;
    @(posedge clk);
    hit = '0;
    if (v && mMon && (d > mHi[ch] || d < mLo[ch])) hit[ch] = 1'b1;
    clr = (wr && a == 5'd24) ? wd[7:0] : 8'h0;
    mSticky = (mSticky & ~clr) | mPend;
    if (mPend != 0) mBus = 1'b1;
    else if (ack && !mMon) mBus = 1'b0;
    mPend = hit;
    if (wr) begin
      if (a < 8) mLo[a[2:0]] = wd;
      else if (a < 16) mHi[a[2:0]] = wd;
      else if (a < 24) mMask[a[2:0]] = wd[3:0];
      else if (a == 5'd25) mMon = wd[0];
    end
    @(negedge clk);
    sampleValid = 1'b0; regWrEn = 1'b0; arAck = 1'b0;
    check_all(tag);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 3'd0, 10'd0, 1'b0, 5'd0, 10'd0, 1'b0, tag);
  endtask

  task automatic wreg(input logic [4:0] a, input logic [9:0] wd, input string tag);
    cyc(1'b0, 3'd0, 10'd0, 1'b1, a, wd, 1'b0, tag);
  endtask

  task automatic samp(input logic [2:0] ch, input logic [9:0] d, input string tag);
    cyc(1'b1, ch, d, 1'b0, 5'd0, 10'd0, 1'b0, tag);
  endtask

  initial begin
    for (int c = 0; c < 8; c++) begin mLo[c] = 0; mHi[c] = 10'h3FF; mMask[c] = 4'hF; end
    mSticky = 0; mPend = 0; mBus = 0; mMon = 1;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R9 reset state");
    samp(3'd5, 10'h3FF, "R9 full scale no alert");
    samp(3'd5, 10'h000, "R9 zero no alert");
    idle("R9 idle");

    // R1 R2 window boundaries on channel 3
    wreg(5'd3, 10'd100, "R1 low write");
    wreg(5'd11, 10'd200, "R1 high write");
    samp(3'd3, 10'd200, "R2 equal high");
    samp(3'd3, 10'd100, "R2 equal low");
    idle("R2 in range"); idle("R2 in range");
    // R3 latency
    samp(3'd3, 10'd201, "R3 edge N not yet");
    chk("R3 status after edge N", 32'(alertStatus), 32'h0);
    idle("R3 set after N+1");
    chk("R3 bit3 set", 32'(alertStatus), 32'h08);
    chk("R6 bus alert low", 32'(busAlertN), 32'h0);
    // R2 below low on channel 3
    wreg(5'd24, 10'h08, "R4 clear bit3");
    chk("R4 cleared", 32'(alertStatus), 32'h0);
    chk("R6 bus held after clear", 32'(busAlertN), 32'h0);
    samp(3'd3, 10'd99, "R2 below low");
    idle("R2 below low set");
    chk("R2 bit3 below", 32'(alertStatus), 32'h08);
    // R4 set wins over clear
    samp(3'd3, 10'd300, "R4 hit");
    cyc(1'b0, 3'd0, 10'd0, 1'b1, 5'd24, 10'h08, 1'b0, "R4 set beats clear");
    chk("R4 set wins", 32'(alertStatus), 32'h08);
    wreg(5'd24, 10'hFF, "R4 clear all");
    // R5 routing mask
    wreg(5'd17, 10'h4, "R5 mask ch1 faultIrq only");
    wreg(5'd9, 10'd50, "R1 ch1 high");
    samp(3'd1, 10'd51, "R5 ch1 hit");
    idle("R5 routed");
    chk("R5 faultIrqN low", 32'(faultIrqN), 32'h0);
    chk("R5 healthyN low", 32'(healthyN), 32'h0);
    chk("R5 faultN high", 32'(faultN), 32'h1);
    // R7 ack ignored while monitoring
    cyc(1'b0, 3'd0, 10'd0, 1'b0, 5'd0, 10'd0, 1'b1, "R7 ack in monitor mode");
    chk("R7 bus stays", 32'(busAlertN), 32'h0);
    wreg(5'd25, 10'h0, "R7 leave monitor");
    // R8 samples ignored
    samp(3'd1, 10'd1000, "R8 ignored sample");
    idle("R8 no set");
    chk("R8 no new bit", 32'(alertStatus), 32'h02);
    cyc(1'b0, 3'd0, 10'd0, 1'b0, 5'd0, 10'd0, 1'b1, "R7 ack clears");
    chk("R7 bus released", 32'(busAlertN), 32'h1);
    wreg(5'd25, 10'h1, "R7 back to monitor");
    wreg(5'd24, 10'hFF, "R4 clear all");

    // constrained random phase
    for (int i = 0; i < 600; i++) begin
      logic v, wr, ack;
      logic [2:0] ch;
      logic [9:0] d, wd;
      logic [4:0] a;
      v   = ($urandom % 10) < 7;
      ch  = 3'($urandom);
      d   = ($urandom % 4 == 0) ? (($urandom % 2) ? mHi[ch] + 10'(($urandom % 3)) - 10'd1
                                                   : mLo[ch] + 10'(($urandom % 3)) - 10'd1)
                                : 10'($urandom);
      wr  = ($urandom % 5) == 0;
      a   = 5'($urandom % 26);
      wd  = 10'($urandom);
      if (a == 5'd25 && ($urandom % 3) != 0) wd[0] = 1'b1;
      ack = ($urandom % 8) == 0;
      cyc(v, ch, d, wr, a, wd, ack, "R2 R4 R5 R6 R7 R8 random");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule